// File: doc/BRIEF.md
# Debounced Pin-to-IRQ Steering

This block takes a small set of general-purpose input pins, two by default, and turns each one into an interrupt request on a line that software chooses. Each pin first crosses into the clock domain through a two-stage synchronizer. A per-pin invert bit then sets which level counts as "asserted". A glitch filter follows, with one counter per pin. It accepts a new asserted or deasserted state only after that state has stayed steady for more than one millisecond. The millisecond is a parameter given as a count of system-clock cycles.

Software programs one small configuration register per pin through a write port. The register holds a 4-bit channel number and the invert bit. A registered read port returns the register picked by the select input. Each filtered, active pin drives one bit of a registered 16-line IRQ bus, and the bit it drives is its channel number. Channel 0 switches the pin off. When two pins share a channel, their requests are ORed onto that line.

Top module: `pin_irq_router`

## Requirements
- R1: While reset is held, and on the first cycle after it, `irq_out` is all zero. Every configuration register reads back as zero (channel 0, no inversion), and every filtered state is deasserted.
- R2: A cycle with `cfg_we` high writes `cfg_wdata` into the register of the pin given by `cfg_sel`. Bits [3:0] are the channel and bit 4 is the invert flag. `cfg_rdata` shows the register of the pin selected at the previous clock edge.
- R3: A pin's asserted state is the pin level XOR its invert bit. If this state changes and then holds for at least CYC_PER_MS+1 cycles, `irq_out` follows exactly CYC_PER_MS+4 clock edges after the pin change, and not one edge earlier.
- R4: A change of the asserted state that lasts CYC_PER_MS cycles or fewer never shows on `irq_out`.
- R5: Changing the invert bit flips the asserted state, and this change passes through the same filter delay as a pin change.
- R6: An active pin with channel c in 1..15 sets only `irq_out[c]`. Line 0 is never driven.
- R7: A pin whose channel is 0 drives no IRQ line, whatever its level.
- R8: Each pin has its own filter and routing. Two pins on different channels drive two lines, and two pins on the same channel drive that one line.
- R9: Rewriting the channel of an active pin moves its request to the new line on the second clock edge after the write is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | NUM_PINS | Asynchronous input pins |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | SEL_W | Pin index for write and read |
| cfg_wdata | input | 5 | Write data: [4] invert, [3:0] channel |
| cfg_rdata | output | 5 | Registered read of the selected pin's register |
| irq_out | output | 16 | IRQ lines, indexed by channel number |

## Verification
A steady level change is applied to a pin and sampled one edge before and at the edge where the output must move. This separates the correct filter delay from a delay that is one cycle short or one cycle long. Pulses of exactly CYC_PER_MS cycles and of CYC_PER_MS+1 cycles set the rejection boundary apart from an off-by-one acceptance. Further sequences drive the state changes through the invert bit, move an active pin to another channel, disable a pin with channel 0, and put both pins on distinct and then shared channels. These separate swapped pins, a shared filter and a wrong routing index.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int IRQ_LINES = 16;
  localparam int CH_W      = $clog2(IRQ_LINES);
  localparam int CFG_W     = CH_W + 1;

  typedef struct packed {
    logic            inv;
    logic [CH_W-1:0] chan;
  } pin_cfg_t;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pin_irq_filter.sv
module pin_irq_filter #(
  parameter int CYC_PER_MS = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic clean
);
  localparam int CNT_W = $clog2(CYC_PER_MS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CYC_PER_MS);

  logic [CNT_W-1:0] run_q;
  logic             state_q;

  // The state flips on the (CYC_PER_MS+1)-th consecutive edge that sees a differing level.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= '0;
      state_q <= 1'b0;
    end else if (raw == state_q) begin
      run_q <= '0;
    end else if (run_q == LIMIT) begin
      run_q   <= '0;
      state_q <= raw;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign clean = state_q;
endmodule

// File: rtl/pin_irq_route.sv
module pin_irq_route
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic     [NUM_PINS-1:0]       live,
  input  pin_cfg_t [NUM_PINS-1:0]       cfg,
  output logic     [IRQ_LINES-1:0]      irq
);
  logic [IRQ_LINES-1:0] irq_nxt;

  always_comb begin
    irq_nxt = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (live[p] && (cfg[p].chan != '0)) begin
        irq_nxt[cfg[p].chan] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else     irq <= irq_nxt;
  end
endmodule

// File: rtl/pin_irq_router.sv
module pin_irq_router
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS   = 2,
  parameter int CYC_PER_MS = 50000,
  parameter int SEL_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PINS-1:0]  pin_in,
  input  logic                 cfg_we,
  input  logic [SEL_W-1:0]     cfg_sel,
  input  logic [CFG_W-1:0]     cfg_wdata,
  output logic [CFG_W-1:0]     cfg_rdata,
  output logic [IRQ_LINES-1:0] irq_out
);
  pin_cfg_t [NUM_PINS-1:0] cfg_q;
  logic     [NUM_PINS-1:0] pin_s;
  logic     [NUM_PINS-1:0] asrt;
  logic     [NUM_PINS-1:0] filt;
  logic                    sel_ok;

  assign sel_ok = int'(cfg_sel) < NUM_PINS;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q     <= '0;
      cfg_rdata <= '0;
    end else begin
      if (cfg_we && sel_ok) cfg_q[cfg_sel] <= pin_cfg_t'(cfg_wdata);
      cfg_rdata <= sel_ok ? CFG_W'(cfg_q[cfg_sel]) : '0;
    end
  end

  pin_irq_sync #(.WIDTH(NUM_PINS), .STAGES(2)) sync_i (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      assign asrt[p] = pin_s[p] ^ cfg_q[p].inv;
      pin_irq_filter #(.CYC_PER_MS(CYC_PER_MS)) filt_i (
        .clk(clk), .rst(rst), .raw(asrt[p]), .clean(filt[p])
      );
    end
  endgenerate

  pin_irq_route #(.NUM_PINS(NUM_PINS)) route_i (
    .clk(clk), .rst(rst), .live(filt), .cfg(cfg_q), .irq(irq_out)
  );
endmodule

// File: rtl/pin_irq_router_chk.sv
module pin_irq_router_chk
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS   = 2,
  parameter int CYC_PER_MS = 50000
) (
  input logic                    clk,
  input logic                    rst,
  input logic [IRQ_LINES-1:0]    irq_out,
  input logic [NUM_PINS-1:0]     asrt,
  input logic [NUM_PINS-1:0]     filt,
  input pin_cfg_t [NUM_PINS-1:0] cfg_q
);
  localparam int HW = $clog2(CYC_PER_MS + 3);
  localparam logic [HW-1:0] HMAX = HW'(CYC_PER_MS + 2);

  logic [NUM_PINS-1:0] any_src;
  logic                any_live;

  always_comb begin
    any_live = 1'b0;
    for (int p = 0; p < NUM_PINS; p++) begin
      any_src[p] = filt[p] && (cfg_q[p].chan != '0);
      any_live   = any_live | any_src[p];
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> irq_out == '0);

  // R6
  line_zero_idle_chk: assert property (@(posedge clk) disable iff (rst) !irq_out[0]);

  // R7
  no_source_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_out != '0) |-> $past(any_live));

  // R8
  line_count_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(irq_out) <= NUM_PINS);

  generate
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
      logic [HW-1:0] hold_q;
      logic          last_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          hold_q <= '0;
          last_q <= 1'b0;
        end else begin
          last_q <= asrt[p];
          if (asrt[p] != last_q) hold_q <= HW'(1);
          else if (hold_q != HMAX) hold_q <= hold_q + 1'b1;
        end
      end

      // R4
      filter_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (filt[p] != $past(filt[p])) |-> ((last_q == filt[p]) && (hold_q >= HW'(CYC_PER_MS + 1))));

      // R6
      route_line_chk: assert property (@(posedge clk) disable iff (rst)
        (filt[p] && (cfg_q[p].chan != '0)) |=> irq_out[$past(cfg_q[p].chan)]);
    end
  endgenerate
endmodule

bind pin_irq_router pin_irq_router_chk #(.NUM_PINS(NUM_PINS), .CYC_PER_MS(CYC_PER_MS)) chk_i (
  .clk(clk), .rst(rst), .irq_out(irq_out), .asrt(asrt), .filt(filt), .cfg_q(cfg_q)
);

// File: tb/pin_irq_router_test.sv
module pin_irq_router_test;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  pin = 2'b00;
  logic        cfg_we = 1'b0;
  logic [0:0]  cfg_sel = 1'b0;
  logic [4:0]  cfg_wdata = '0;
  logic [4:0]  cfg_rdata;
  logic [15:0] irq_out;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_router #(.NUM_PINS(2), .CYC_PER_MS(N)) uut (
    .clk(clk), .rst(rst), .pin_in(pin), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_out(irq_out)
  );

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(int p, logic inv, logic [3:0] ch);
    cfg_sel   = 1'(p);
    cfg_wdata = {inv, ch};
    cfg_we    = 1'b1;
    tick(1);
    cfg_we    = 1'b0;
  endtask

  function automatic logic [15:0] bit_of(int c);
    return 16'(1) << c;
  endfunction

  task automatic t_reset();
    rst = 1'b1;
    tick(3);
    chk("R1 irq during reset", irq_out, '0);
    rst = 1'b0;
    tick(1);
    chk("R1 irq after reset", irq_out, '0);
    chk("R1 cfg readback", 16'(cfg_rdata), '0);
  endtask

  task automatic t_readback();
    cfg_write(0, 1'b0, 4'd5);
    cfg_write(1, 1'b1, 4'd10);
    cfg_sel = 1'b0;
    tick(1);
    chk("R2 readback pin0", 16'(cfg_rdata), 16'h05);
    cfg_sel = 1'b1;
    tick(1);
    chk("R2 readback pin1", 16'(cfg_rdata), 16'h1A);
    cfg_write(1, 1'b0, 4'd0);
    tick(N + 6);
    chk("R7 pin1 off no line", irq_out, '0);
  endtask

  task automatic t_latency();
    pin[0] = 1'b1;
    tick(N + 3);
    chk("R3 rise not early", irq_out, '0);
    tick(1);
    chk("R3 rise on time R6", irq_out, bit_of(5));
    pin[0] = 1'b0;
    tick(N + 3);
    chk("R3 fall not early", irq_out, bit_of(5));
    tick(1);
    chk("R3 fall on time", irq_out, '0);
  endtask

  task automatic t_glitch();
    pin[0] = 1'b1;
    tick(N);
    pin[0] = 1'b0;
    for (int i = 0; i < N + 6; i++) begin
      tick(1);
      chk("R4 pulse of N rejected", irq_out, '0);
    end
    pin[0] = 1'b1;
    tick(1);
    pin[0] = 1'b0;
    tick(N + 6);
    chk("R4 one-cycle glitch rejected", irq_out, '0);
    pin[0] = 1'b1;
    tick(N + 1);
    pin[0] = 1'b0;
    tick(3);
    chk("R4 pulse of N+1 accepted", irq_out, bit_of(5));
    tick(N + 6);
    chk("R4 accepted pulse released", irq_out, '0);
  endtask

  task automatic t_polarity();
    cfg_write(0, 1'b1, 4'd5);
    tick(N + 1);
    chk("R5 invert not early", irq_out, '0);
    tick(1);
    chk("R5 invert asserts low pin", irq_out, bit_of(5));
    pin[0] = 1'b1;
    tick(N + 4);
    chk("R5 high pin inactive when inverted", irq_out, '0);
    cfg_write(0, 1'b0, 4'd5);
    tick(N + 6);
    chk("R5 invert cleared", irq_out, bit_of(5));
  endtask

  task automatic t_rechannel();
    cfg_write(0, 1'b0, 4'd12);
    chk("R9 old line one edge after", irq_out, bit_of(5));
    tick(1);
    chk("R9 new line two edges after", irq_out, bit_of(12));
  endtask

  task automatic t_disable();
    cfg_write(0, 1'b0, 4'd0);
    tick(1);
    chk("R7 channel 0 drops line", irq_out, '0);
    tick(N + 6);
    chk("R7 channel 0 stays quiet", irq_out, '0);
  endtask

  task automatic t_two_pins();
    cfg_write(0, 1'b0, 4'd3);
    cfg_write(1, 1'b0, 4'd9);
    pin[1] = 1'b1;
    tick(N + 6);
    chk("R8 two distinct lines", irq_out, bit_of(3) | bit_of(9));
    pin[0] = 1'b0;
    tick(N + 4);
    chk("R8 pin0 released alone", irq_out, bit_of(9));
    pin[0] = 1'b1;
    cfg_write(0, 1'b0, 4'd7);
    cfg_write(1, 1'b0, 4'd7);
    tick(N + 6);
    chk("R8 shared line", irq_out, bit_of(7));
    cfg_write(0, 1'b0, 4'd15);
    tick(1);
    chk("R6 top line", irq_out, bit_of(15) | bit_of(7));
  endtask

  initial begin
    tick(0);
    t_reset();
    t_readback();
    t_latency();
    t_glitch();
    t_polarity();
    t_rechannel();
    t_disable();
    t_two_pins();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule